// File: doc/BRIEF.md
# Beam Position Frame Decoder

This block sits behind a serial link receiver that delivers 16-bit words, one per clock, on the recovered data clock. It looks for the start of each beam position frame, gathers the payload, and checks the frame's CRC-16. For every frame that passes the check it emits a single 128-bit AXI4-Stream beat carrying both position coordinates, the monitor identifier, a 40-bit timestamp and the low byte of the sequence number. The link must always be served, so the block has no backpressure and downstream logic takes every beat.

Besides the data path, the block tracks link health. A frame with a bad CRC is dropped, flagged with a one-cycle pulse and counted. Good frames are grouped by their sequence number. A jump in that number that is not a plain step of one is flagged and counted. The number of frames seen in the last finished sequence is presented as a status value.

Top module: `bpd_decoder`

## Requirements
- R1: A frame on the wire is a start word (default 0xBC95), then 9 payload words, then one CRC word. Only cycles with word_valid_i high carry words. While no frame is open, every valid word that is not the start word is discarded.
- R2: The CRC is CRC-16 with polynomial 0x1021 and initial value 0xFFFF. It is computed MSB first over the 9 payload words, with no final inversion. When it equals the CRC word, one output beat is produced.
- R3: The beat appears in the cycle after the CRC word is taken. m_axis_tvalid_o is high for exactly that one cycle, and m_axis_tlast_o is high with it.
- R4: The payload words arrive in this order: monitor ID, sequence number, x[31:16], x[15:0], y[31:16], y[15:0], a timestamp word whose low byte is ts[39:32] (its high byte is ignored), ts[31:16], ts[15:0]. m_axis_tdata_o carries, from bit 127 down: x (32 bits), y (32 bits), ID (16 bits), ts (40 bits), and sequence bits [7:0].
- R5: On a CRC mismatch no beat is produced. frame_error_o pulses for one cycle in the cycle a beat would have appeared. crc_err_count_o rises by one in the following cycle. Sequence tracking is not affected.
- R6: Take a good frame whose sequence number differs from the current one and is not the current one plus 1 (modulo 2^16). Such a frame raises seq_discontinuity_o for one cycle, one cycle after its beat, and seq_disc_count_o rises by one in that same cycle.
- R7: When a good frame carries a sequence number different from the current one, seq_frame_count_o takes, one cycle after the beat, the number of good frames that carried the previous number. Otherwise it holds its value.
- R8: A synchronous reset clears all outputs, counters and the sequence tracking. The first good frame after reset raises no discontinuity and leaves seq_frame_count_o at 0.
- R9: Frames may follow each other with no idle cycle, the next start word coming in the cycle after a CRC word, and each good one still yields its beat.
- R10: Once a frame is open, a payload or CRC word equal to the start word is treated as data and does not restart the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Recovered data clock |
| rst_i | input | 1 | Synchronous reset, active high |
| word_i | input | 16 | Deserialized link word |
| word_valid_i | input | 1 | word_i carries a word this cycle |
| m_axis_tvalid_o | output | 1 | Output beat valid, one cycle per good frame |
| m_axis_tdata_o | output | 128 | Packed position packet |
| m_axis_tlast_o | output | 1 | End of packet, high with every beat |
| frame_error_o | output | 1 | One-cycle pulse on a CRC mismatch |
| seq_discontinuity_o | output | 1 | One-cycle pulse on a sequence jump |
| crc_err_count_o | output | CNT_W | Count of frames with a bad CRC |
| seq_disc_count_o | output | CNT_W | Count of sequence jumps |
| seq_frame_count_o | output | FRAME_CNT_W | Frames in the last finished sequence |

## Verification
The assertions take the link framing for granted: a frame needs at least eleven valid words, so two beats can never come in adjacent cycles, and a discontinuity or a change of the frame count can only follow a beat. The stimulus always sends whole frames. It inserts idle cycles and garbage words only between frames or as invalid cycles, so that spacing holds throughout. Random sequence numbers are drawn to mostly repeat or step by one, with occasional jumps and corrupted CRC words. The directed cases cover the start word appearing inside a payload, the sequence wrapping from 0xFFFF to 0, bursts with no gaps, and reset in the middle of a run.

// File: rtl/bpd_pkg.sv
package bpd_pkg;

    localparam int WORD_W      = 16;
    localparam int PAY_WORDS   = 9;
    localparam int PAY_W       = WORD_W * PAY_WORDS;
    localparam int IDX_W       = $clog2(PAY_WORDS);
    localparam int ID_W        = 16;
    localparam int SEQ_W       = 16;
    localparam int POS_W       = 32;
    localparam int TS_W        = 40;
    localparam int SEQ_OUT_W   = 8;
    localparam int PKT_W       = 2 * POS_W + ID_W + TS_W + SEQ_OUT_W;

    // field offsets in the payload shift register (first word ends on top)
    localparam int ID_LSB      = PAY_W - ID_W;
    localparam int SEQ_LSB     = ID_LSB - SEQ_W;
    localparam int X_LSB       = SEQ_LSB - POS_W;
    localparam int Y_LSB       = X_LSB - POS_W;
    localparam int TS_LSB      = 0;

    localparam logic [15:0] CRC_POLY = 16'h1021;
    localparam logic [15:0] CRC_INIT = 16'hFFFF;

    typedef enum logic [1:0] {
        PH_HUNT  = 2'd0,
        PH_BODY  = 2'd1,
        PH_CHECK = 2'd2
    } phase_e;

    typedef struct packed {
        logic [POS_W-1:0]     pos_x;
        logic [POS_W-1:0]     pos_y;
        logic [ID_W-1:0]      mon_id;
        logic [TS_W-1:0]      stamp;
        logic [SEQ_OUT_W-1:0] seq_lo;
    } bpm_pkt_t;

    // one word through the CRC register, most significant bit first
    function automatic logic [15:0] crc16_word(input logic [15:0] crc,
                                               input logic [WORD_W-1:0] data);
        logic [15:0] c;
        logic        fb;
        c = crc;
        for (int i = WORD_W - 1; i >= 0; i--) begin
            fb = c[15] ^ data[i];
            c  = {c[14:0], 1'b0};
            if (fb) c = c ^ CRC_POLY;
        end
        return c;
    endfunction

    function automatic bpm_pkt_t unpack_payload(input logic [PAY_W-1:0] p);
        bpm_pkt_t k;
        k.pos_x  = p[X_LSB +: POS_W];
        k.pos_y  = p[Y_LSB +: POS_W];
        k.mon_id = p[ID_LSB +: ID_W];
        k.stamp  = p[TS_LSB +: TS_W];
        k.seq_lo = p[SEQ_LSB +: SEQ_OUT_W];
        return k;
    endfunction

endpackage

// File: rtl/bpd_framer.sv
module bpd_framer
    import bpd_pkg::*;
#(
    parameter logic [WORD_W-1:0] START_WORD = 16'hBC95
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic             word_valid_i,
    output logic             done_o,
    output logic             crc_ok_o,
    output logic [PAY_W-1:0] payload_o
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PAY_WORDS - 1);

    typedef struct packed {
        phase_e             phase;
        logic [IDX_W-1:0]   idx;
        logic [15:0]        crc;
        logic [PAY_W-1:0]   payload;
        logic               done;
        logic               ok;
    } fr_state_t;

    fr_state_t s_q, s_d;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        s_d.ok   = 1'b0;
        if (word_valid_i) begin
            case (s_q.phase)
                PH_HUNT: begin
                    if (word_i == START_WORD) begin
                        s_d.phase = PH_BODY;
                        s_d.idx   = '0;
                        s_d.crc   = CRC_INIT;
                    end
                end
                PH_BODY: begin
                    s_d.crc     = crc16_word(s_q.crc, word_i);
                    s_d.payload = {s_q.payload[PAY_W-WORD_W-1:0], word_i};
                    if (s_q.idx == LAST_IDX) begin
                        s_d.phase = PH_CHECK;
                    end else begin
                        s_d.idx = s_q.idx + 1'b1;
                    end
                end
                PH_CHECK: begin
                    s_d.done  = 1'b1;
                    s_d.ok    = (word_i == s_q.crc);
                    s_d.phase = PH_HUNT;
                end
                default: s_d.phase = PH_HUNT;
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign done_o    = s_q.done;
    assign crc_ok_o  = s_q.ok;
    assign payload_o = s_q.payload;

endmodule

// File: rtl/bpd_seq_tracker.sv
module bpd_seq_tracker
    import bpd_pkg::*;
#(
    parameter int CNT_W       = 32,
    parameter int FRAME_CNT_W = 16
) (
    input  logic                   clk_i,
    input  logic                   rst_i,
    input  logic                   frame_done_i,
    input  logic                   frame_ok_i,
    input  logic [SEQ_W-1:0]       seq_i,
    output logic [CNT_W-1:0]       err_cnt_o,
    output logic [CNT_W-1:0]       disc_cnt_o,
    output logic                   disc_pulse_o,
    output logic [FRAME_CNT_W-1:0] last_frames_o
);

    typedef struct packed {
        logic                   have_seq;
        logic [SEQ_W-1:0]       cur_seq;
        logic [FRAME_CNT_W-1:0] cur_frames;
        logic [FRAME_CNT_W-1:0] last_frames;
        logic [CNT_W-1:0]       err_cnt;
        logic [CNT_W-1:0]       disc_cnt;
        logic                   disc;
    } trk_state_t;

    trk_state_t t_q, t_d;

    always_comb begin
        t_d      = t_q;
        t_d.disc = 1'b0;
        if (frame_done_i) begin
            if (!frame_ok_i) begin
                t_d.err_cnt = t_q.err_cnt + 1'b1;
            end else if (!t_q.have_seq) begin
                t_d.have_seq   = 1'b1;
                t_d.cur_seq    = seq_i;
                t_d.cur_frames = FRAME_CNT_W'(1);
            end else if (seq_i == t_q.cur_seq) begin
                t_d.cur_frames = t_q.cur_frames + 1'b1;
            end else begin
                t_d.last_frames = t_q.cur_frames;
                t_d.cur_frames  = FRAME_CNT_W'(1);
                t_d.cur_seq     = seq_i;
                if (seq_i != SEQ_W'(t_q.cur_seq + 1'b1)) begin
                    t_d.disc     = 1'b1;
                    t_d.disc_cnt = t_q.disc_cnt + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            t_q <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    assign err_cnt_o     = t_q.err_cnt;
    assign disc_cnt_o    = t_q.disc_cnt;
    assign disc_pulse_o  = t_q.disc;
    assign last_frames_o = t_q.last_frames;

endmodule

// File: rtl/bpd_decoder.sv
module bpd_decoder
    import bpd_pkg::*;
#(
    parameter logic [15:0] START_WORD  = 16'hBC95,
    parameter int          CNT_W       = 32,
    parameter int          FRAME_CNT_W = 16
) (
    input  logic                   clk_i,
    input  logic                   rst_i,
    input  logic [15:0]            word_i,
    input  logic                   word_valid_i,
    output logic                   m_axis_tvalid_o,
    output logic [127:0]           m_axis_tdata_o,
    output logic                   m_axis_tlast_o,
    output logic                   frame_error_o,
    output logic                   seq_discontinuity_o,
    output logic [CNT_W-1:0]       crc_err_count_o,
    output logic [CNT_W-1:0]       seq_disc_count_o,
    output logic [FRAME_CNT_W-1:0] seq_frame_count_o
);

    logic             fr_done;
    logic             fr_ok;
    logic [PAY_W-1:0] fr_payload;
    bpm_pkt_t         pkt;

    bpd_framer #(
        .START_WORD (START_WORD)
    ) u_framer (
        .clk_i        (clk_i),
        .rst_i        (rst_i),
        .word_i       (word_i),
        .word_valid_i (word_valid_i),
        .done_o       (fr_done),
        .crc_ok_o     (fr_ok),
        .payload_o    (fr_payload)
    );

    bpd_seq_tracker #(
        .CNT_W       (CNT_W),
        .FRAME_CNT_W (FRAME_CNT_W)
    ) u_tracker (
        .clk_i         (clk_i),
        .rst_i         (rst_i),
        .frame_done_i  (fr_done),
        .frame_ok_i    (fr_ok),
        .seq_i         (fr_payload[SEQ_LSB +: SEQ_W]),
        .err_cnt_o     (crc_err_count_o),
        .disc_cnt_o    (seq_disc_count_o),
        .disc_pulse_o  (seq_discontinuity_o),
        .last_frames_o (seq_frame_count_o)
    );

    assign pkt             = unpack_payload(fr_payload);
    assign m_axis_tvalid_o = fr_done & fr_ok;
    assign m_axis_tdata_o  = pkt;
    assign m_axis_tlast_o  = 1'b1;
    assign frame_error_o   = fr_done & ~fr_ok;

endmodule

// File: rtl/bpd_decoder_chk.sv
module bpd_decoder_chk #(
    parameter int CNT_W       = 32,
    parameter int FRAME_CNT_W = 16
) (
    input logic                   clk_i,
    input logic                   rst_i,
    input logic                   m_axis_tvalid_o,
    input logic                   m_axis_tlast_o,
    input logic                   frame_error_o,
    input logic                   seq_discontinuity_o,
    input logic [CNT_W-1:0]       crc_err_count_o,
    input logic [CNT_W-1:0]       seq_disc_count_o,
    input logic [FRAME_CNT_W-1:0] seq_frame_count_o
);

    // R3
    beat_tlast_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        m_axis_tvalid_o |-> m_axis_tlast_o);

    // R3
    beat_single_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        m_axis_tvalid_o |=> !m_axis_tvalid_o);

    // R5
    err_no_beat_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        frame_error_o |-> !m_axis_tvalid_o);

    // R5
    err_count_step_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        frame_error_o |=> (crc_err_count_o == $past(crc_err_count_o) + 1'b1));

    // R5
    err_count_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !frame_error_o |=> $stable(crc_err_count_o));

    // R6
    disc_after_beat_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        seq_discontinuity_o |-> $past(m_axis_tvalid_o));

    // R6
    disc_count_move_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !$stable(seq_disc_count_o) |-> seq_discontinuity_o);

    // R7
    frames_after_beat_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !$stable(seq_frame_count_o) |-> $past(m_axis_tvalid_o));

endmodule

bind bpd_decoder bpd_decoder_chk #(
    .CNT_W       (CNT_W),
    .FRAME_CNT_W (FRAME_CNT_W)
) u_chk (
    .clk_i               (clk_i),
    .rst_i               (rst_i),
    .m_axis_tvalid_o     (m_axis_tvalid_o),
    .m_axis_tlast_o      (m_axis_tlast_o),
    .frame_error_o       (frame_error_o),
    .seq_discontinuity_o (seq_discontinuity_o),
    .crc_err_count_o     (crc_err_count_o),
    .seq_disc_count_o    (seq_disc_count_o),
    .seq_frame_count_o   (seq_frame_count_o)
);

// File: tb/bpd_decoder_tb.sv
`timescale 1ns/1ps
module bpd_decoder_tb;

    localparam logic [15:0] START = 16'hBC95;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [15:0]  word = '0;
    logic         wv = 1'b0;
    logic         tvalid, tlast, ferr, sdisc;
    logic [127:0] tdata;
    logic [31:0]  err_cnt, disc_cnt;
    logic [15:0]  frm_cnt;

    always #2 clk = ~clk;

    bpd_decoder u_dut (
        .clk_i               (clk),
        .rst_i               (rst),
        .word_i              (word),
        .word_valid_i        (wv),
        .m_axis_tvalid_o     (tvalid),
        .m_axis_tdata_o      (tdata),
        .m_axis_tlast_o      (tlast),
        .frame_error_o       (ferr),
        .seq_discontinuity_o (sdisc),
        .crc_err_count_o     (err_cnt),
        .seq_disc_count_o    (disc_cnt),
        .seq_frame_count_o   (frm_cnt)
    );

    int    checks = 0;
    int    errors = 0;
    bit    finished = 0;
    string ctx = "R2";

    // reference model of the sequence tracking
    bit          m_have = 0;
    logic [15:0] m_cur = '0;
    logic [15:0] m_frames = '0;
    logic [15:0] m_last = '0;
    logic [31:0] m_err = '0;
    logic [31:0] m_disc = '0;

    bit           pend_beat = 0, pend_track = 0;
    bit           exp_good = 0, exp_disc = 0;
    logic [127:0] exp_data = '0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s (%s) %s: actual=%0h expected=%0h", req, ctx, what, act, exp);
        end
    endtask

    // byte-wise reference CRC-16, poly 0x1021
    function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [15:0] d);
        logic [7:0] b;
        for (int n = 0; n < 2; n++) begin
            b = (n == 0) ? d[15:8] : d[7:0];
            c = c ^ {b, 8'h00};
            for (int i = 0; i < 8; i++) c = c[15] ? ((c << 1) ^ 16'h1021) : (c << 1);
        end
        return c;
    endfunction

    task automatic tick(input bit v, input logic [15:0] w);
        @(negedge clk);
        if (pend_track) begin
            chk(sdisc == exp_disc, "R6", "seq_discontinuity", 128'(sdisc), 128'(exp_disc));
            chk(disc_cnt == m_disc, "R6", "seq_disc_count", 128'(disc_cnt), 128'(m_disc));
            chk(err_cnt == m_err, "R5", "crc_err_count", 128'(err_cnt), 128'(m_err));
            chk(frm_cnt == m_last, "R7", "seq_frame_count", 128'(frm_cnt), 128'(m_last));
            pend_track = 0;
        end else begin
            chk(sdisc == 1'b0, "R6", "stray discontinuity", 128'(sdisc), 128'(0));
        end
        if (pend_beat) begin
            chk(tvalid == exp_good, "R2", "tvalid on frame end", 128'(tvalid), 128'(exp_good));
            chk(ferr == !exp_good, "R5", "frame_error on frame end", 128'(ferr), 128'(!exp_good));
            if (exp_good) begin
                chk(tlast == 1'b1, "R3", "tlast", 128'(tlast), 128'(1));
                chk(tdata == exp_data, "R4", "tdata", tdata, exp_data);
            end
            pend_beat  = 0;
            pend_track = 1;
        end else begin
            chk(tvalid == 1'b0, "R3", "stray tvalid", 128'(tvalid), 128'(0));
            chk(ferr == 1'b0, "R5", "stray frame_error", 128'(ferr), 128'(0));
        end
        wv   = v;
        word = w;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick(1'b0, 16'($urandom));
    endtask

    task automatic send_frame(input logic [15:0] id, input logic [15:0] seq,
                              input logic [31:0] x, input logic [31:0] y,
                              input logic [39:0] ts, input bit corrupt, input bit gaps);
        logic [15:0] w [11];
        logic [15:0] c;
        w[0]  = START;
        w[1]  = id;
        w[2]  = seq;
        w[3]  = x[31:16];
        w[4]  = x[15:0];
        w[5]  = y[31:16];
        w[6]  = y[15:0];
        w[7]  = {8'($urandom), ts[39:32]};
        w[8]  = ts[31:16];
        w[9]  = ts[15:0];
        c = 16'hFFFF;
        for (int k = 1; k <= 9; k++) c = ref_crc(c, w[k]);
        w[10] = corrupt ? (c ^ (16'h1 << ($urandom % 16))) : c;
        for (int k = 0; k < 11; k++) begin
            if (gaps && k > 0 && ($urandom % 4) == 0) tick(1'b0, 16'($urandom));
            tick(1'b1, w[k]);
        end
        exp_disc = 0;
        if (corrupt) begin
            exp_good = 0;
            m_err    = m_err + 1;
        end else begin
            exp_good = 1;
            exp_data = {x, y, id, ts, seq[7:0]};
            if (!m_have) begin
                m_have = 1; m_cur = seq; m_frames = 16'd1;
            end else if (seq == m_cur) begin
                m_frames = m_frames + 1;
            end else begin
                exp_disc = (seq != 16'(m_cur + 1));
                if (exp_disc) m_disc = m_disc + 1;
                m_last   = m_frames;
                m_frames = 16'd1;
                m_cur    = seq;
            end
        end
        pend_beat = 1;
    endtask

    task automatic rand_frame(input bit corrupt, input bit gaps);
        logic [15:0] s;
        int r;
        r = $urandom % 100;
        if (r < 50) s = m_cur;
        else if (r < 85) s = m_cur + 16'd1;
        else s = 16'($urandom);
        send_frame(16'($urandom), s, $urandom, $urandom, {8'($urandom), 32'($urandom)},
                   corrupt, gaps);
    endtask

    task automatic check_cleared(input string tag);
        @(negedge clk);
        chk(tvalid == 1'b0, tag, "tvalid after reset", 128'(tvalid), 128'(0));
        chk(ferr == 1'b0, tag, "frame_error after reset", 128'(ferr), 128'(0));
        chk(sdisc == 1'b0, tag, "discontinuity after reset", 128'(sdisc), 128'(0));
        chk(err_cnt == 0, tag, "crc_err_count after reset", 128'(err_cnt), 128'(0));
        chk(disc_cnt == 0, tag, "seq_disc_count after reset", 128'(disc_cnt), 128'(0));
        chk(frm_cnt == 0, tag, "seq_frame_count after reset", 128'(frm_cnt), 128'(0));
    endtask

    task automatic model_reset();
        m_have = 0; m_cur = '0; m_frames = '0; m_last = '0; m_err = '0; m_disc = '0;
    endtask

    initial begin
        void'($urandom(32'd1937));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        ctx = "R8";
        check_cleared("R8");

        // first frame after reset: no discontinuity, frame count stays 0 (R8)
        send_frame(16'h0011, 16'd5, 32'h1234_5678, 32'h9ABC_DEF0, 40'h01_2345_6789, 0, 0);
        idle(3);
        ctx = "R7";
        send_frame(16'h0012, 16'd5, 32'hFFFF_FFFF, 32'h0, 40'hFF_FFFF_FFFF, 0, 0);
        send_frame(16'h0013, 16'd5, 32'h8000_0001, 32'h7FFF_FFFE, 40'h80_0000_0001, 0, 0);
        send_frame(16'h0014, 16'd6, 32'h1, 32'h2, 40'h3, 0, 0);
        idle(3);
        ctx = "R6";
        send_frame(16'h0015, 16'd9, 32'hCAFE_0000, 32'h0000_BEEF, 40'h55_AAAA_5555, 0, 0);
        idle(2);
        ctx = "R5";
        send_frame(16'h0016, 16'd40, 32'h0, 32'h0, 40'h0, 1, 0);
        send_frame(16'h0017, 16'd10, 32'h10, 32'h20, 40'h30, 0, 0);
        idle(2);

        // garbage words before the start word, idle cycles inside the frame (R1)
        ctx = "R1";
        for (int i = 0; i < 6; i++) begin
            logic [15:0] g;
            g = 16'($urandom);
            if (g == START) g = g ^ 16'h1;
            tick(1'b1, g);
        end
        send_frame(16'h0101, 16'd10, 32'hA5A5_5A5A, 32'h0F0F_F0F0, 40'h12_3456_789A, 0, 1);
        idle(2);

        // start word inside the payload is data (R10)
        ctx = "R10";
        send_frame(START, 16'd11, {START, START}, {START, 16'h0}, {8'h95, START, START}, 0, 0);
        idle(2);

        // sequence wrap is a plain step (R6)
        ctx = "R6";
        send_frame(16'h0200, 16'hFFFF, 32'h1, 32'h1, 40'h1, 0, 0);
        send_frame(16'h0201, 16'h0000, 32'h2, 32'h2, 40'h2, 0, 0);
        idle(2);

        // back-to-back burst (R9)
        ctx = "R9";
        for (int i = 0; i < 8; i++) rand_frame(i == 3, 0);
        idle(3);

        // random traffic
        ctx = "R2";
        for (int i = 0; i < 300; i++) begin
            rand_frame(($urandom % 100) < 15, ($urandom % 2) == 1);
            if (($urandom % 3) == 0) idle(1 + $urandom % 4);
        end
        idle(3);

        // reset in the middle of a run (R8)
        ctx = "R8";
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        model_reset();
        check_cleared("R8");
        send_frame(16'h0300, 16'd100, 32'h77, 32'h88, 40'h99, 0, 0);
        idle(3);
        chk(frm_cnt == 16'd0, "R8", "frame count after first frame", 128'(frm_cnt), 128'(0));
        chk(disc_cnt == 32'd0, "R8", "no discontinuity after first frame", 128'(disc_cnt), 128'(0));

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule